// File: doc/BRIEF.md
# Nonvolatile Store/Recall Cycle Sequencer

This block sequences the nonvolatile cycles of a memory that pairs an SRAM array with a shadow nonvolatile array. It takes store requests from three sources: a software pulse, a power-fail pulse, and an active-low busy line shared by several devices that some other agent has held low. It takes recall requests from a software pulse and from a power-up pulse. A store runs as an erase phase and then a program phase. A recall runs as an SRAM clear phase and then a copy phase. Each phase lasts a fixed number of clock cycles set by a parameter. The arrays themselves sit outside the block. They follow the phase code and the one-cycle phase-end strobe that this block drives.

The block also gates host access to the SRAM. Each access is offered with `acc_valid`, and `acc_we` marks it as a write. An access is taken in a cycle where `acc_valid` and `acc_ready` are both high. An access that is not taken is not performed, and the host has to hold it or drop it. `acc_ready` depends on the current state and on `acc_we`, never on `acc_valid`. The busy line passes through a synchronizer before use. The block pulls the line low for the whole of every store. It keeps all SRAM access shut after a store, and after a skipped pin-started store, until the line reads high again.

Top module: `nv_cycle_ctrl`

## Requirements
- R1: After reset the block is idle: `nv_phase` is 0, `busy_pull_low` is 0 and `acc_ready` is 1.
- R2: While idle, every access is accepted (`acc_ready`=1), and an accepted write marks the SRAM as modified since the last store.
- R3: A software store request always starts a store on the next cycle, even with no write since the last store. The store shows `nv_phase`=1 (erase) for ERASE_CYC cycles, then `nv_phase`=2 (program) for PROG_CYC cycles.
- R4: `busy_pull_low` is 1 in exactly the cycles where a store phase is in progress.
- R5: A power-fail request starts a store only if a write was accepted since the last store began. Otherwise it has no effect.
- R6: A recall shows `nv_phase`=3 (clear) for CLEAR_CYC cycles, then `nv_phase`=4 (copy) for COPY_CYC cycles, with the busy line released. It then returns straight to idle.
- R7: A store request and a recall request in the same idle cycle start the store. Requests that arrive while a cycle is in progress are dropped.
- R8: While any phase is in progress, `acc_ready` is 0.
- R9: The busy line passes through SYNC_STAGES flops. Once the synchronized low has been seen, reads stay accepted for GRACE cycles and writes are refused.
- R10: A low on the busy line that lasts fewer than MIN_PULSE synchronized cycles (the first cycle it is seen counts) has no effect, and the block returns to idle.
- R11: A qualified low starts a store, if the SRAM is modified, when the grace window runs out or in the cycle after a `bus_event`, whichever comes first. If the SRAM is not modified, the store is skipped.
- R12: After a store, or after a skipped pin-started store, `acc_ready` stays 0 until the synchronized busy line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_store_req | input | 1 | Software store request pulse |
| sw_recall_req | input | 1 | Software recall request pulse |
| pfail_store_req | input | 1 | Power-fail store request pulse |
| pwrup_recall_req | input | 1 | Power-up recall request pulse |
| busy_line | input | 1 | Sensed level of the shared active-low busy line |
| busy_pull_low | output | 1 | Enables the open-drain pull-down on the busy line |
| bus_event | input | 1 | Strobe for any address or control transition |
| acc_valid | input | 1 | Host offers an SRAM access |
| acc_we | input | 1 | The offered access is a write |
| acc_ready | output | 1 | The offered access is accepted this cycle |
| nv_phase | output | 3 | 0 none, 1 erase, 2 program, 3 clear, 4 copy |
| phase_done | output | 1 | Last cycle of the current phase |

## Verification
The bench goes after the edges of the pin path. One test holds the line low for one cycle less than the qualifying width, and a design that counted wrongly would store there. One test holds the line low with the SRAM unmodified, and a design that lost the dirty state would program anyway or fail to inhibit. One test offers writes inside the grace window, and a design that took them would then answer a later power-fail with a store. It also checks that a store request and a recall request in the same cycle start the store, and that a recall request during a store is dropped. It measures the exact cycle where a store starts after grace expiry and after a bus event, and the exact cycle where access reopens after the line is released, so an off-by-one in the synchronizer or in the hold state shows up as a miscompare.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PINWAIT = 3'd1,
    ST_ERASE   = 3'd2,
    ST_PROG    = 3'd3,
    ST_CLEAR   = 3'd4,
    ST_COPY    = 3'd5,
    ST_HOLD    = 3'd6
  } nvc_state_e;

  localparam logic [2:0] PH_NONE  = 3'd0;
  localparam logic [2:0] PH_ERASE = 3'd1;
  localparam logic [2:0] PH_PROG  = 3'd2;
  localparam logic [2:0] PH_CLEAR = 3'd3;
  localparam logic [2:0] PH_COPY  = 3'd4;

  function automatic logic [2:0] phase_of(nvc_state_e s);
    case (s)
      ST_ERASE: phase_of = PH_ERASE;
      ST_PROG:  phase_of = PH_PROG;
      ST_CLEAR: phase_of = PH_CLEAR;
      ST_COPY:  phase_of = PH_COPY;
      default:  phase_of = PH_NONE;
    endcase
  endfunction
endpackage

// File: rtl/nvc_busy_sync.sv
module nvc_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic line_sync
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= line_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign line_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nvc_pin_watch.sv
module nvc_pin_watch #(
  parameter int MIN_PULSE = 4,
  parameter int GRACE     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic line_hi,
  input  logic bus_event,
  output logic rd_open,
  output logic fire,
  output logic abandon
);
  localparam int LIMIT = (MIN_PULSE > GRACE) ? MIN_PULSE : GRACE;
  localparam int CW    = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] CMAX      = CW'(LIMIT + 1);
  localparam logic [CW-1:0] QUAL_AT   = CW'((MIN_PULSE > 2) ? MIN_PULSE - 2 : 0);
  localparam logic [CW-1:0] GRACE_LIM = CW'(GRACE);

  logic [CW-1:0] low_cnt_q;
  logic          cut_q;
  logic          qual_q;
  logic          qual_now;
  logic          window;

  // The cycle in which idle first saw the low counts as one, so the
  // pulse qualifies when this counter reaches MIN_PULSE-2 with the line low.
  assign qual_now = qual_q | (!line_hi && (low_cnt_q >= QUAL_AT));
  assign window   = (low_cnt_q < GRACE_LIM) && !cut_q && !bus_event;

  assign rd_open  = active && window;
  assign fire     = active && qual_now && !window;
  assign abandon  = active && line_hi && !qual_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      cut_q     <= 1'b0;
      qual_q    <= 1'b0;
    end else if (!active) begin
      low_cnt_q <= '0;
      cut_q     <= 1'b0;
      qual_q    <= 1'b0;
    end else begin
      if (low_cnt_q != CMAX) low_cnt_q <= low_cnt_q + 1'b1;
      cut_q  <= cut_q | bus_event;
      qual_q <= qual_now;
    end
  end
endmodule

// File: rtl/nvc_phase_timer.sv
module nvc_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] len,
  output logic          last
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == (len - TW'(1)));
endmodule

// File: rtl/nv_cycle_ctrl.sv
module nv_cycle_ctrl
  import nvc_pkg::*;
#(
  parameter int ERASE_CYC   = 6,
  parameter int PROG_CYC    = 10,
  parameter int CLEAR_CYC   = 4,
  parameter int COPY_CYC    = 8,
  parameter int MIN_PULSE   = 4,
  parameter int GRACE       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_store_req,
  input  logic       sw_recall_req,
  input  logic       pfail_store_req,
  input  logic       pwrup_recall_req,
  input  logic       busy_line,
  output logic       busy_pull_low,
  input  logic       bus_event,
  input  logic       acc_valid,
  input  logic       acc_we,
  output logic       acc_ready,
  output logic [2:0] nv_phase,
  output logic       phase_done
);
  localparam int M1     = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int M2     = (CLEAR_CYC > COPY_CYC) ? CLEAR_CYC : COPY_CYC;
  localparam int MAXLEN = (M1 > M2) ? M1 : M2;
  localparam int TW     = $clog2(MAXLEN + 1);

  nvc_state_e st_q, st_d;
  logic       line_hi;
  logic       dirty_q;
  logic       pin_rd_open, pin_fire, pin_abandon;
  logic       t_last;
  logic [TW-1:0] t_len;
  logic       in_nv;
  logic       store_entry;

  nvc_busy_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_async (busy_line),
    .line_sync  (line_hi)
  );

  nvc_pin_watch #(.MIN_PULSE(MIN_PULSE), .GRACE(GRACE)) i_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (st_q == ST_PINWAIT),
    .line_hi   (line_hi),
    .bus_event (bus_event),
    .rd_open   (pin_rd_open),
    .fire      (pin_fire),
    .abandon   (pin_abandon)
  );

  always_comb begin
    case (st_q)
      ST_ERASE: t_len = TW'(ERASE_CYC);
      ST_PROG:  t_len = TW'(PROG_CYC);
      ST_CLEAR: t_len = TW'(CLEAR_CYC);
      ST_COPY:  t_len = TW'(COPY_CYC);
      default:  t_len = TW'(1);
    endcase
  end

  nvc_phase_timer #(.TW(TW)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st_d != st_q),
    .len     (t_len),
    .last    (t_last)
  );

  // Store requests outrank recall requests; the pin is looked at last.
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (sw_store_req || (pfail_store_req && dirty_q)) st_d = ST_ERASE;
        else if (sw_recall_req || pwrup_recall_req)       st_d = ST_CLEAR;
        else if (!line_hi)                                st_d = ST_PINWAIT;
      end
      ST_PINWAIT: begin
        if (pin_fire)         st_d = dirty_q ? ST_ERASE : ST_HOLD;
        else if (pin_abandon) st_d = ST_IDLE;
      end
      ST_ERASE: if (t_last) st_d = ST_PROG;
      ST_PROG:  if (t_last) st_d = ST_HOLD;
      ST_CLEAR: if (t_last) st_d = ST_COPY;
      ST_COPY:  if (t_last) st_d = ST_IDLE;
      ST_HOLD:  if (line_hi) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign store_entry = (st_d == ST_ERASE) && (st_q != ST_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        dirty_q <= 1'b0;
    else if (store_entry)                              dirty_q <= 1'b0;
    else if (st_q == ST_IDLE && acc_valid && acc_we)   dirty_q <= 1'b1;
  end

  always_comb begin
    case (st_q)
      ST_IDLE:    acc_ready = 1'b1;
      ST_PINWAIT: acc_ready = pin_rd_open && !acc_we;
      default:    acc_ready = 1'b0;
    endcase
  end

  assign nv_phase      = phase_of(st_q);
  assign in_nv         = (nv_phase != PH_NONE);
  assign phase_done    = in_nv && t_last;
  assign busy_pull_low = (st_q == ST_ERASE) || (st_q == ST_PROG);
endmodule

// File: rtl/nvc_checker.sv
module nvc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_pull_low,
  input logic       acc_ready,
  input logic [2:0] nv_phase
);
  a_r4_pull_matches_store: assert property (@(posedge clk) disable iff (!rst_n)
    busy_pull_low == (nv_phase == 3'd1 || nv_phase == 3'd2));

  a_r8_closed_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_phase != 3'd0) |-> !acc_ready);

  a_r3_program_follows_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_phase == 3'd2 && $past(nv_phase) != 3'd2) |-> $past(nv_phase) == 3'd1);

  a_r6_copy_follows_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_phase == 3'd4 && $past(nv_phase) != 3'd4) |-> $past(nv_phase) == 3'd3);

  a_r6_recall_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nv_phase) == 3'd4 && nv_phase != 3'd4) |-> nv_phase == 3'd0);

  a_r12_closed_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nv_phase) == 3'd2 && nv_phase != 3'd2) |-> !acc_ready);
endmodule

bind nv_cycle_ctrl nvc_checker i_nvc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy_pull_low (busy_pull_low),
  .acc_ready     (acc_ready),
  .nv_phase      (nv_phase)
);

// File: tb/test_nv_cycle_ctrl.sv
module test_nv_cycle_ctrl;
  localparam int ERASE_CYC = 6;
  localparam int PROG_CYC  = 10;
  localparam int CLEAR_CYC = 4;
  localparam int COPY_CYC  = 8;
  localparam int MIN_PULSE = 4;
  localparam int GRACE     = 8;
  localparam int SYNC      = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_store_req = 0, sw_recall_req = 0, pfail_store_req = 0, pwrup_recall_req = 0;
  logic ext_n = 1'b1;
  logic bus_event = 0, acc_valid = 0, acc_we = 0;
  logic busy_pull_low, acc_ready, phase_done;
  logic [2:0] nv_phase;
  wire busy_line = ext_n & ~busy_pull_low;

  int nvec = 0;
  int nerr = 0;

  int ph  [0:255];
  int rdy [0:255];
  int bsy [0:255];

  always #2.5 clk = ~clk;

  nv_cycle_ctrl #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .CLEAR_CYC(CLEAR_CYC),
    .COPY_CYC(COPY_CYC), .MIN_PULSE(MIN_PULSE), .GRACE(GRACE), .SYNC_STAGES(SYNC)
  ) i_nv_cycle_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
    .pfail_store_req(pfail_store_req), .pwrup_recall_req(pwrup_recall_req),
    .busy_line(busy_line), .busy_pull_low(busy_pull_low), .bus_event(bus_event),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_ready(acc_ready),
    .nv_phase(nv_phase), .phase_done(phase_done)
  );

  // Expected cycle numbers, counted from the cycle the external low starts.
  function automatic int f_pinwait_first(); return SYNC + 1; endfunction
  function automatic int f_grace_store_start(); return SYNC + 1 + GRACE + 1; endfunction
  function automatic int f_reopen_after_release(); return SYNC + 1; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic next_cyc();
    @(posedge clk); #1;
  endtask

  task automatic record(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ph[i] = nv_phase; rdy[i] = acc_ready; bsy[i] = busy_pull_low;
      next_cyc();
    end
  endtask

  function automatic int first_of(input int code, input int n);
    for (int i = 0; i < n; i++) if (ph[i] == code) return i;
    return -1;
  endfunction

  function automatic int run_of(input int code, input int from, input int n);
    int k = 0;
    if (from < 0) return 0;
    for (int i = from; i < n && ph[i] == code; i++) k++;
    return k;
  endfunction

  function automatic int count_pull_mismatch(input int n);
    int k = 0;
    for (int i = 0; i < n; i++) if ((bsy[i] != 0) != (ph[i] == 1 || ph[i] == 2)) k++;
    return k;
  endfunction

  task automatic pulse_pfail(); pfail_store_req = 1; next_cyc(); pfail_store_req = 0; endtask
  task automatic pulse_sw_store(); sw_store_req = 1; next_cyc(); sw_store_req = 0; endtask

  task automatic wait_open();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (acc_ready && nv_phase == 0) begin next_cyc(); return; end
      next_cyc();
    end
    chk(0, "wait_open timeout", 0, 1);
  endtask

  task automatic one_write();
    acc_valid = 1; acc_we = 1; next_cyc(); acc_valid = 0; acc_we = 0;
  endtask

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int e0, p0, c0, k, pf;
    void'($urandom(32'd2024));
    repeat (3) next_cyc();
    rst_n = 1; next_cyc();

    // R1 reset state
    @(negedge clk);
    chk_eq("R1 phase", nv_phase, 0);
    chk_eq("R1 pull", busy_pull_low, 0);
    chk_eq("R1 ready", acc_ready, 1);
    next_cyc();

    // R2 random idle traffic
    pf = 0;
    for (int i = 0; i < 200; i++) begin
      acc_valid = $urandom_range(0, 1); acc_we = $urandom_range(0, 1);
      @(negedge clk);
      if (!acc_ready || nv_phase != 0) pf++;
      next_cyc();
    end
    acc_valid = 0; acc_we = 0;
    chk_eq("R2 idle accepts all", pf, 0);
    one_write();

    // R5 power-fail store with write pending; R3 R4 phase lengths
    pulse_pfail();
    record(40);
    e0 = first_of(1, 40);
    chk_eq("R5 pfail dirty starts store", e0, 0);
    chk_eq("R3 erase length", run_of(1, e0, 40), ERASE_CYC);
    p0 = e0 + ERASE_CYC;
    chk_eq("R3 program length", run_of(2, p0, 40), PROG_CYC);
    chk_eq("R4 pull only in store", count_pull_mismatch(40), 0);
    chk_eq("R12 closed after store", rdy[p0 + PROG_CYC], 0);
    wait_open();

    // R5 power-fail with no write: nothing
    pulse_pfail();
    record(30);
    chk_eq("R5 pfail clean ignored", first_of(1, 30), -1);
    chk_eq("R5 ready stays", rdy[10], 1);

    // R3 software store runs with no write
    pulse_sw_store();
    record(30);
    chk_eq("R3 sw store clean", first_of(1, 30), 0);
    chk_eq("R3 sw store program", run_of(2, ERASE_CYC, 30), PROG_CYC);
    wait_open();

    // R6 recall
    sw_recall_req = 1; next_cyc(); sw_recall_req = 0;
    record(20);
    c0 = first_of(3, 20);
    chk_eq("R6 clear start", c0, 0);
    chk_eq("R6 clear length", run_of(3, c0, 20), CLEAR_CYC);
    chk_eq("R6 copy length", run_of(4, CLEAR_CYC, 20), COPY_CYC);
    chk_eq("R6 back to idle", ph[CLEAR_CYC + COPY_CYC], 0);
    chk_eq("R6 ready after recall", rdy[CLEAR_CYC + COPY_CYC], 1);
    chk_eq("R6 no pull", count_pull_mismatch(20), 0);

    // R7 priority, then a recall request during the store is dropped; R8
    sw_store_req = 1; pwrup_recall_req = 1; next_cyc();
    sw_store_req = 0; pwrup_recall_req = 0;
    @(negedge clk);
    chk_eq("R7 store wins", nv_phase, 1);
    next_cyc();
    sw_recall_req = 1; acc_valid = 1; next_cyc(); sw_recall_req = 0;
    record(60);
    acc_valid = 0;
    chk_eq("R7 recall in cycle dropped", first_of(3, 60), -1);
    pf = 0;
    for (int i = 0; i < 60; i++) if (ph[i] != 0 && rdy[i] != 0) pf++;
    chk_eq("R8 closed during cycle", pf, 0);
    wait_open();

    // R10 short low: no effect, write state kept
    one_write();
    ext_n = 0;
    for (int i = 0; i < MIN_PULSE - 1; i++) next_cyc();
    ext_n = 1;
    record(30);
    chk_eq("R10 short low no store", first_of(1, 30), -1);
    chk_eq("R10 back idle ready", rdy[29], 1);
    pulse_pfail();
    @(negedge clk);
    chk_eq("R10 write kept", nv_phase, 1);
    next_cyc();
    wait_open();

    // R9 writes refused in grace; R11 clean skip; R12 hold
    ext_n = 0;
    k = 0; pf = 0;
    for (int i = 0; i < f_grace_store_start() + 4; i++) begin
      if (i >= f_pinwait_first() && i < f_pinwait_first() + GRACE) begin
        acc_valid = 1; acc_we = 1;
      end else begin
        acc_valid = 0; acc_we = 0;
      end
      @(negedge clk);
      if (acc_valid && acc_ready) k++;
      if (nv_phase != 0) pf++;
      next_cyc();
    end
    acc_valid = 0; acc_we = 0;
    chk_eq("R9 writes refused", k, 0);
    chk_eq("R11 clean pin skips store", pf, 0);
    @(negedge clk);
    chk_eq("R12 hold while low", acc_ready, 0);
    next_cyc();
    ext_n = 1;
    record(f_reopen_after_release() + 1);
    chk_eq("R12 still closed", rdy[f_reopen_after_release() - 1], 0);
    chk_eq("R12 reopen", rdy[f_reopen_after_release()], 1);
    pulse_pfail();
    record(10);
    chk_eq("R9 refused write left clean", first_of(1, 10), -1);

    // R11 grace expiry with write pending; R9 reads open for GRACE
    one_write();
    ext_n = 0;
    acc_valid = 1; acc_we = 0;
    record(f_grace_store_start() + 2);
    acc_valid = 0;
    chk_eq("R11 store at grace end", first_of(1, f_grace_store_start() + 2), f_grace_store_start());
    k = 0;
    for (int i = f_pinwait_first(); i < f_grace_store_start(); i++) k += rdy[i];
    chk_eq("R9 read window", k, GRACE);
    record(ERASE_CYC + PROG_CYC + 10);
    chk_eq("R12 hold while held low", rdy[ERASE_CYC + PROG_CYC + 5], 0);
    ext_n = 1;
    wait_open();

    // R11 bus event cuts the grace window
    one_write();
    ext_n = 0;
    acc_valid = 1;
    for (int i = 0; i < f_pinwait_first() + MIN_PULSE; i++) next_cyc();
    bus_event = 1;
    @(negedge clk);
    chk_eq("R11 event closes window", acc_ready, 0);
    next_cyc();
    bus_event = 0; acc_valid = 0;
    ext_n = 1;
    @(negedge clk);
    chk_eq("R11 store after event", nv_phase, 1);
    next_cyc();
    wait_open();

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule